// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Core

This block is the clocked control core between a motor controller and the six power switches of a three-phase half bridge. Each phase has one command pin for the upper switch and one for the lower switch, both active low. Every command is synchronised and then filtered so that short glitches never reach a gate. A per-phase state machine turns the filtered commands into gate enables. It never lets both switches of a leg conduct, and it keeps both off for a programmable dead time before either may turn on.

A protection section sits above the three legs. An overcurrent input latches a fault that switches off all six gates at once. The latch is ignored for a blanking window after any gate turns on, so switching spikes cannot trip it. It is released only by a clear pulse given while the overcurrent input is inactive. A shutdown input and an undervoltage input also switch everything off, but only for as long as they are active. Any of the three conditions drives the active-low fault flag low. All time values are parameters counted in clock cycles.

Each leg runs the states LEG_OFF, LEG_HI and LEG_LO:
- LEG_OFF moves to LEG_HI when the dead time has elapsed, nothing is killing the outputs and only the upper side is requested.
- LEG_OFF moves to LEG_LO under the same conditions when only the lower side is requested.
- LEG_HI and LEG_LO return to LEG_OFF when their request drops, the request conflicts with the other side, or a kill is present. This return clears the dead-time count.

The protection machine has the states FLT_RUN and FLT_LATCHED:
- FLT_RUN moves to FLT_LATCHED when the synchronised trip is high and the blanking count is zero.
- FLT_LATCHED moves back to FLT_RUN when the synchronised clear is high and the synchronised trip is low.

Top module: `gate_drive_guard`

## Requirements
- R1: Each gate output is high while its command input (cmd_hi_n[p] for gate_hi[p], cmd_lo_n[p] for gate_lo[p]) is held low, and low while that input is held high; bit p of every bus belongs to phase p.
- R2: A command change that is held steady reaches its gate output exactly FILT_CYC+3 clock edges after the first edge that samples it, provided the dead time is already met.
- R3: A command level held for fewer than FILT_CYC sampling edges has no effect on the outputs; a level held for FILT_CYC edges or more is accepted.
- R4: Before any gate of a phase turns on, both gates of that phase have been low for at least DEAD_CYC cycles; on a direct swap from one side to the other, both are low for exactly DEAD_CYC cycles.
- R5: gate_hi[p] and gate_lo[p] are never high in the same cycle.
- R6: While both commands of a phase are low, both gates of that phase stay low; the other phases are unaffected.
- R7: While shut is high, all six gates go low 2 edges after shut is first sampled and fault_n is low; after shut falls, fault_n returns high and the gates follow the commands again.
- R8: supply_low acts on the gates and fault_n exactly as shut does, with the same 2-edge latency.
- R9: oc_trip high outside the blanking window forces all six gates low and fault_n low 3 edges after it is first sampled, and both stay so after oc_trip falls.
- R10: oc_trip is ignored while fewer than BLANK_CYC edges have passed since any gate turned on.
- R11: A fault_clr pulse releases the overcurrent latch only while oc_trip is low; fault_n goes high 3 edges after fault_clr is first sampled, and the commanded gates turn on one edge later.
- R12: While rst_n is low, all gates are low, fault_n is high and the overcurrent latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi_n | input | N_PHASE | Upper switch commands, active low |
| cmd_lo_n | input | N_PHASE | Lower switch commands, active low |
| oc_trip | input | 1 | Overcurrent detected, active high |
| shut | input | 1 | External shutdown, active high |
| supply_low | input | 1 | Gate supply undervoltage, active high |
| fault_clr | input | 1 | Overcurrent latch release, active high |
| gate_hi | output | N_PHASE | Upper gate enables, active high |
| gate_lo | output | N_PHASE | Lower gate enables, active high |
| fault_n | output | 1 | Fault flag, active low |

## Verification
Inputs are driven on falling edges and counted in rising edges from then on. A command reaches its gate after FILT_CYC+3 edges. Shutdown and undervoltage act after 2 edges, overcurrent after 3. A clear raises the flag after 3 edges and brings the gates back after 4. Latency checks sample the edge before the due edge and the due edge itself, so a result that comes early fails as surely as one that comes late. The dead-time check counts the off samples between the falling gate and the rising gate, and the glitch check watches the output over a whole window instead of a single instant.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_state_t;

    typedef enum logic {
        FLT_RUN     = 1'b0,
        FLT_LATCHED = 1'b1
    } flt_state_t;

endpackage

// File: rtl/gdp_glitch_filter.sv
module gdp_glitch_filter #(
    parameter int FILT_CYC = 78
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic clean_n
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILT_CYC - 1);

    logic          sy1, sy2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1     <= 1'b1;
            sy2     <= 1'b1;
            clean_n <= 1'b1;
            run_cnt <= '0;
        end else begin
            sy1 <= raw_n;
            sy2 <= sy1;
            if (sy2 != clean_n) begin
                if (run_cnt == CMAX) begin
                    clean_n <= sy2;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/gdp_phase_leg.sv
module gdp_phase_leg
    import gdp_pkg::*;
#(
    parameter int DEAD_CYC = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    input  logic kill,
    output logic drv_hi,
    output logic drv_lo,
    output logic turn_on
);
    localparam int DW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DMAX = DW'(DEAD_CYC - 1);

    leg_state_t    state, state_nx;
    logic [DW-1:0] dead_cnt, dead_nx;
    logic          only_hi, only_lo, dead_ok;

    assign only_hi = want_hi & ~want_lo;
    assign only_lo = want_lo & ~want_hi;
    assign dead_ok = (dead_cnt == DMAX);

    always_comb begin
        state_nx = state;
        dead_nx  = dead_cnt;
        unique case (state)
            LEG_OFF: begin
                if (!dead_ok) dead_nx = dead_cnt + 1'b1;
                if (dead_ok && !kill) begin
                    if (only_hi)      state_nx = LEG_HI;
                    else if (only_lo) state_nx = LEG_LO;
                end
            end
            LEG_HI: begin
                if (kill || !only_hi) begin
                    state_nx = LEG_OFF;
                    dead_nx  = '0;
                end
            end
            LEG_LO: begin
                if (kill || !only_lo) begin
                    state_nx = LEG_OFF;
                    dead_nx  = '0;
                end
            end
            default: begin
                state_nx = LEG_OFF;
                dead_nx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= LEG_OFF;
            dead_cnt <= DMAX;
        end else begin
            state    <= state_nx;
            dead_cnt <= dead_nx;
        end
    end

    always_comb begin
        drv_hi  = (state == LEG_HI) && !kill;
        drv_lo  = (state == LEG_LO) && !kill;
        turn_on = (state == LEG_OFF) && (state_nx != LEG_OFF);
    end
endmodule

// File: rtl/gdp_fault_keeper.sv
module gdp_fault_keeper
    import gdp_pkg::*;
#(
    parameter int BLANK_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic shut,
    input  logic uv,
    input  logic clr,
    input  logic any_turn_on,
    output logic kill,
    output logic fault_n
);
    localparam int BW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] BLOAD = BW'(BLANK_CYC);

    flt_state_t    state, state_nx;
    logic [1:0]    trip_sy, shut_sy, uv_sy, clr_sy;
    logic [BW-1:0] blank_cnt;
    logic          trip_s, shut_s, uv_s, clr_s;

    assign trip_s = trip_sy[1];
    assign shut_s = shut_sy[1];
    assign uv_s   = uv_sy[1];
    assign clr_s  = clr_sy[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_sy   <= '0;
            shut_sy   <= '0;
            uv_sy     <= '0;
            clr_sy    <= '0;
            blank_cnt <= '0;
        end else begin
            trip_sy <= {trip_sy[0], trip};
            shut_sy <= {shut_sy[0], shut};
            uv_sy   <= {uv_sy[0], uv};
            clr_sy  <= {clr_sy[0], clr};
            if (any_turn_on)          blank_cnt <= BLOAD;
            else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLT_RUN:     if (trip_s && blank_cnt == '0) state_nx = FLT_LATCHED;
            FLT_LATCHED: if (clr_s && !trip_s)          state_nx = FLT_RUN;
            default:                                    state_nx = FLT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLT_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        kill    = (state == FLT_LATCHED) | shut_s | uv_s;
        fault_n = ~kill;
    end
endmodule

// File: rtl/gate_drive_guard.sv
module gate_drive_guard #(
    parameter int N_PHASE   = 3,
    parameter int FILT_CYC  = 78,
    parameter int DEAD_CYC  = 175,
    parameter int BLANK_CYC = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] cmd_hi_n,
    input  logic [N_PHASE-1:0] cmd_lo_n,
    input  logic               oc_trip,
    input  logic               shut,
    input  logic               supply_low,
    input  logic               fault_clr,
    output logic [N_PHASE-1:0] gate_hi,
    output logic [N_PHASE-1:0] gate_lo,
    output logic               fault_n
);
    logic [N_PHASE-1:0] filt_hi_n, filt_lo_n, leg_on;
    logic               kill;

    for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
        gdp_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_hi (
            .clk(clk), .rst_n(rst_n), .raw_n(cmd_hi_n[p]), .clean_n(filt_hi_n[p])
        );
        gdp_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt_lo (
            .clk(clk), .rst_n(rst_n), .raw_n(cmd_lo_n[p]), .clean_n(filt_lo_n[p])
        );
        gdp_phase_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst_n(rst_n),
            .want_hi(~filt_hi_n[p]), .want_lo(~filt_lo_n[p]), .kill(kill),
            .drv_hi(gate_hi[p]), .drv_lo(gate_lo[p]), .turn_on(leg_on[p])
        );
    end

    gdp_fault_keeper #(.BLANK_CYC(BLANK_CYC)) u_fault (
        .clk(clk), .rst_n(rst_n), .trip(oc_trip), .shut(shut), .uv(supply_low),
        .clr(fault_clr), .any_turn_on(|leg_on), .kill(kill), .fault_n(fault_n)
    );
endmodule

// File: rtl/gate_drive_guard_chk.sv
module gate_drive_guard_chk #(
    parameter int N_PHASE  = 3,
    parameter int DEAD_CYC = 175
) (
    input logic               clk,
    input logic               rst_n,
    input logic               shut,
    input logic               supply_low,
    input logic [N_PHASE-1:0] gate_hi,
    input logic [N_PHASE-1:0] gate_lo,
    input logic               fault_n
);
    localparam int OW = $clog2(DEAD_CYC + 1) + 1;

    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    a_r7_shut_kills: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shut) && $past(shut, 2)) |-> (gate_hi == '0 && gate_lo == '0 && !fault_n));

    a_r8_uv_kills: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(supply_low) && $past(supply_low, 2)) |-> (gate_hi == '0 && gate_lo == '0 && !fault_n));

    a_r9_flag_means_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_hi == '0 && gate_lo == '0));

    for (genvar p = 0; p < N_PHASE; p++) begin : g_dead
        logic [OW-1:0] off_cnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       off_cnt <= OW'(DEAD_CYC);
            else if (gate_hi[p] | gate_lo[p]) off_cnt <= '0;
            else if (off_cnt < OW'(DEAD_CYC)) off_cnt <= off_cnt + 1'b1;
        end
        a_r4_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hi[p]) || $rose(gate_lo[p])) |-> (off_cnt >= OW'(DEAD_CYC)));
    end
endmodule

bind gate_drive_guard gate_drive_guard_chk #(.N_PHASE(N_PHASE), .DEAD_CYC(DEAD_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .shut(shut), .supply_low(supply_low),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
);

// File: tb/gate_drive_guard_bench.sv
module gate_drive_guard_bench;
    localparam int NP    = 3;
    localparam int FILT  = 4;
    localparam int DEAD  = 8;
    localparam int BLANK = 6;
    localparam int HOLD  = 40;

    // fields: [11:9] cmd_hi_n, [8:6] cmd_lo_n, [5:3] gate_hi, [2:0] gate_lo
    localparam logic [11:0] VEC [6] = '{
        {3'b111, 3'b111, 3'b000, 3'b000},
        {3'b110, 3'b111, 3'b001, 3'b000},
        {3'b111, 3'b110, 3'b000, 3'b001},
        {3'b100, 3'b101, 3'b001, 3'b000},
        {3'b011, 3'b110, 3'b100, 3'b001},
        {3'b000, 3'b111, 3'b111, 3'b000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] cmd_hi_n = '1;
    logic [NP-1:0] cmd_lo_n = '1;
    logic          oc_trip = 1'b0;
    logic          shut = 1'b0;
    logic          supply_low = 1'b0;
    logic          fault_clr = 1'b0;
    logic [NP-1:0] gate_hi, gate_lo;
    logic          fault_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gate_drive_guard #(.N_PHASE(NP), .FILT_CYC(FILT), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) u_gate_drive_guard (
        .clk(clk), .rst_n(rst_n), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
        .oc_trip(oc_trip), .shut(shut), .supply_low(supply_low), .fault_clr(fault_clr),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] gates();
        return {2'b00, gate_hi, gate_lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int gap;
        bit seen, fallen, risen;
        wait_n(3);
        // R12: reset state
        chk("R12 gates in reset", gates(), 8'h00);
        chk("R12 flag in reset", {7'd0, fault_n}, 8'h01);
        rst_n = 1'b1;
        wait_n(5);

        // R1, R6: vector table
        for (int i = 0; i < 6; i++) begin
            cmd_hi_n = VEC[i][11:9];
            cmd_lo_n = VEC[i][8:6];
            wait_n(HOLD);
            chk($sformatf("R1 vec%0d gate_hi", i), {5'd0, gate_hi}, {5'd0, VEC[i][5:3]});
            chk($sformatf("R6 vec%0d gate_lo", i), {5'd0, gate_lo}, {5'd0, VEC[i][2:0]});
        end
        cmd_hi_n = '1; cmd_lo_n = '1;
        wait_n(HOLD);

        // R2: exact latency
        cmd_hi_n = 3'b110;
        wait_n(FILT + 2);
        chk("R2 one edge early", {5'd0, gate_hi}, 8'h00);
        wait_n(1);
        chk("R2 on due edge", {5'd0, gate_hi}, 8'h01);
        cmd_hi_n = '1;
        wait_n(HOLD);

        // R3: short pulse rejected, FILT-long pulse accepted
        cmd_lo_n = 3'b101;
        wait_n(FILT - 1);
        cmd_lo_n = '1;
        seen = 1'b0;
        for (int k = 0; k < 30; k++) begin
            wait_n(1);
            if (gate_lo[1]) seen = 1'b1;
        end
        chk("R3 short pulse ignored", {7'd0, seen}, 8'h00);
        cmd_lo_n = 3'b101;
        wait_n(FILT);
        cmd_lo_n = '1;
        seen = 1'b0;
        for (int k = 0; k < 30; k++) begin
            wait_n(1);
            if (gate_lo[1]) seen = 1'b1;
        end
        chk("R3 full pulse accepted", {7'd0, seen}, 8'h01);
        wait_n(HOLD);

        // R4: exact dead gap on a direct swap
        cmd_hi_n = 3'b110;
        wait_n(HOLD);
        cmd_hi_n = '1; cmd_lo_n = 3'b110;
        gap = 0; fallen = 1'b0; risen = 1'b0;
        for (int k = 0; k < 60; k++) begin
            wait_n(1);
            if (!gate_hi[0]) fallen = 1'b1;
            if (gate_lo[0]) risen = 1'b1;
            if (fallen && !risen && !gate_hi[0] && !gate_lo[0]) gap++;
        end
        chk("R4 dead gap", 8'(gap), 8'(DEAD));
        cmd_lo_n = '1;
        wait_n(HOLD);

        // R7: shutdown, not latched
        cmd_hi_n = 3'b110; cmd_lo_n = 3'b101;
        wait_n(HOLD);
        shut = 1'b1;
        wait_n(1);
        chk("R7 still on after one edge", gates(), 8'h0a);
        wait_n(1);
        chk("R7 off after two edges", gates(), 8'h00);
        chk("R7 flag low", {7'd0, fault_n}, 8'h00);
        shut = 1'b0;
        wait_n(HOLD);
        chk("R7 restored", {fault_n, gates()[6:0]}, 8'h8a);

        // R8: undervoltage
        supply_low = 1'b1;
        wait_n(2);
        chk("R8 off and flag low", {fault_n, gates()[6:0]}, 8'h00);
        supply_low = 1'b0;
        wait_n(HOLD);
        chk("R8 restored", {fault_n, gates()[6:0]}, 8'h8a);

        // R10: trip inside blanking window ignored
        cmd_hi_n = '1; cmd_lo_n = '1;
        wait_n(HOLD);
        cmd_hi_n = 3'b011;
        while (!gate_hi[2]) wait_n(1);
        oc_trip = 1'b1;
        wait_n(2);
        oc_trip = 1'b0;
        wait_n(20);
        chk("R10 blanked trip", {fault_n, gates()[6:0]}, 8'h a0);
        cmd_hi_n = 3'b110; cmd_lo_n = 3'b101;
        wait_n(HOLD);

        // R9: latched overcurrent
        oc_trip = 1'b1;
        wait_n(2);
        chk("R9 on after two edges", gates(), 8'h0a);
        wait_n(1);
        chk("R9 off after three edges", {fault_n, gates()[6:0]}, 8'h00);
        oc_trip = 1'b0;
        wait_n(20);
        chk("R9 stays latched", {fault_n, gates()[6:0]}, 8'h00);

        // R11: clear blocked while trip active, then effective
        oc_trip = 1'b1;
        fault_clr = 1'b1;
        wait_n(10);
        chk("R11 clear blocked", {fault_n, gates()[6:0]}, 8'h00);
        fault_clr = 1'b0; oc_trip = 1'b0;
        wait_n(10);
        fault_clr = 1'b1;
        wait_n(3);
        chk("R11 flag released", {fault_n, gates()[6:0]}, 8'h80);
        wait_n(1);
        chk("R11 gates follow", {fault_n, gates()[6:0]}, 8'h8a);
        fault_clr = 1'b0;
        wait_n(HOLD);

        // R12: reset clears a latched trip
        oc_trip = 1'b1;
        wait_n(5);
        oc_trip = 1'b0;
        wait_n(5);
        chk("R12 latched before reset", {7'd0, fault_n}, 8'h00);
        rst_n = 1'b0;
        wait_n(2);
        chk("R12 reset clears latch", {fault_n, gates()[6:0]}, 8'h80);
        rst_n = 1'b1;
        wait_n(HOLD);
        chk("R12 runs after reset", {fault_n, gates()[6:0]}, 8'h8a);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule